// File: doc/BRIEF.md
# Reset Source Capture Controller

This block merges six reset requests into a single system reset and keeps a record of which requests caused it. The requests are an active-low external pin, a power-on detect, a brownout detect, a watchdog timeout, a software request and a UART break-detect request. The pin may instead serve as an ordinary digital input, selected by a configuration enable bit. Right after power-up that bit is overridden, and the pin always behaves as a reset input until the first reset release.

The system reset output is held low for a fixed stretch of clock cycles after the last active request and is released on a clock edge. A six-bit cause register is read and cleared over a minimal register bus. Writing a 0 to a bit clears it and writing a 1 leaves it alone. Only power-on resets the cause register itself. A watchdog timeout rewrites the register as if power had been cycled. Every other request adds its own bit and keeps the bits that are already set.

Cause bit positions: [0] pin, [1] power-on, [2] brownout, [3] watchdog, [4] software, [5] UART break.

Top module: `rst_cause_ctrl`

## Requirements
- R1: `pin_value` equals the level of `pin_rst_n` after two rising clock edges, whatever the enable bit is.
- R2: With `pin_en` = 1, a low synchronized pin asserts `sys_rst_n` low and sets cause bit [0].
- R3: With `pin_en` = 0 after the power-up window, a low pin causes no reset and leaves cause bit [0] unchanged.
- R4: From power-on until the first release of `sys_rst_n`, a low pin acts as a reset whatever `pin_en` is, so a pin held low keeps the system in reset. After that release, `pin_en` alone decides again.
- R5: `por_n` low asynchronously drives `sys_rst_n` low and loads the cause register with 6'b000110 (power-on and brownout bits).
- R6: A watchdog timeout loads the cause register with 6'b001110, OR-ed with the bits of any other request active in the same cycle. A bus write in that cycle is ignored.
- R7: A brownout, software, UART break or pin request sets its own cause bit on the next edge and leaves the other bits as they were.
- R8: A bus write clears each cause bit written as 0. Bits written as 1 keep their value.
- R9: When a bus write and a request fall in the same cycle, the request's bit ends up set.
- R10: `sys_rst_n` goes low at the first edge where any request is sampled active. It returns high exactly at the 16th rising edge after the last edge with an active request, with no active request at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on detect, active low, asynchronous |
| pin_rst_n | input | 1 | External pin, raw and asynchronous |
| pin_en | input | 1 | 1: pin acts as reset input; 0: data input only |
| bod_det | input | 1 | Brownout detect request |
| wdt_expire | input | 1 | Watchdog timeout request |
| sw_req | input | 1 | Software reset request |
| brk_req | input | 1 | UART break-detect reset request |
| flag_wr | input | 1 | Cause register write strobe |
| flag_wdata | input | 6 | Write data, 0 clears the bit |
| flag_rdata | output | 6 | Cause register contents |
| pin_value | output | 1 | Synchronized pin level |
| sys_rst_n | output | 1 | Stretched system reset, active low |

## Verification
On every cycle, assertions check the flag-update rules that involve a single step. These are the watchdog rewrite, a software request setting its bit, and a write clearing only the bits written as 0. They also check that an active request forces the reset low, that a release never follows an active request, that a disabled pin outside the power-up window cannot start a reset, and that a low pin inside that window holds it. Other behaviour can only be shown by the bench's scenarios: the exact 16-cycle release point, the asynchronous effect of power-on, the two-edge pin latency and the end of the power-up override.

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl #(
  parameter int STRETCH     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       pin_rst_n,
  input  logic       pin_en,
  input  logic       bod_det,
  input  logic       wdt_expire,
  input  logic       sw_req,
  input  logic       brk_req,
  input  logic       flag_wr,
  input  logic [5:0] flag_wdata,
  output logic [5:0] flag_rdata,
  output logic       pin_value,
  output logic       sys_rst_n
);

  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [5:0] POR_PATTERN = 6'b000110;
  localparam logic [5:0] WDT_PATTERN = 6'b001110;

  logic [SYNC_STAGES-1:0] pin_sync;
  logic [CW-1:0]          cnt;
  logic [5:0]             flags, hit, flags_nxt;
  logic                   pwrup, pin_req, act, release_now;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) pin_sync <= '1;
    else        pin_sync <= {pin_sync[SYNC_STAGES-2:0], pin_rst_n};

  assign pin_value = pin_sync[SYNC_STAGES-1];
  assign pin_req   = !pin_value && (pin_en || pwrup);
  assign hit       = {brk_req, sw_req, wdt_expire, bod_det, 1'b0, pin_req};
  assign act       = |hit;
  assign release_now = !act && (cnt <= CW'(1));

  assign flags_nxt = wdt_expire ? (WDT_PATTERN | hit)
                                : ((flag_wr ? (flags & flag_wdata) : flags) | hit);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) flags <= POR_PATTERN;
    else        flags <= flags_nxt;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      cnt       <= CW'(STRETCH);
      sys_rst_n <= 1'b0;
      pwrup     <= 1'b1;
    end else begin
      if (act)           cnt <= CW'(STRETCH);
      else if (cnt != 0) cnt <= cnt - CW'(1);
      sys_rst_n <= release_now;
      if (release_now) pwrup <= 1'b0;
    end

  assign flag_rdata = flags;

  a_r6_wdt_flags: assert property (@(posedge clk) disable iff (!por_n)
    wdt_expire |=> (flag_rdata[3:1] == 3'b111));

  a_r7_sw_sets: assert property (@(posedge clk) disable iff (!por_n)
    sw_req |=> flag_rdata[4]);

  a_r8_clear_only: assert property (@(posedge clk) disable iff (!por_n)
    (flag_wr && !act) |=> (flag_rdata == ($past(flag_rdata) & $past(flag_wdata))));

  a_r10_active_holds: assert property (@(posedge clk) disable iff (!por_n)
    act |=> !sys_rst_n);

  a_r10_quiet_release: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> !$past(act));

  a_r3_pin_gated: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst_n && !pin_en && !pwrup && !bod_det && !wdt_expire && !sw_req && !brk_req)
      |=> sys_rst_n);

  a_r4_pwrup_hold: assert property (@(posedge clk) disable iff (!por_n)
    (pwrup && !pin_value) |=> !sys_rst_n);

endmodule

// File: tb/rst_cause_ctrl_tb.sv
`timescale 1ns/1ps
module rst_cause_ctrl_tb;
  logic clk = 1'b0;
  logic por_n, pin_rst_n, pin_en, bod_det, wdt_expire, sw_req, brk_req, flag_wr;
  logic [5:0] flag_wdata, flag_rdata;
  logic pin_value, sys_rst_n;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rst_cause_ctrl u_dut (
    .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .pin_en(pin_en),
    .bod_det(bod_det), .wdt_expire(wdt_expire), .sw_req(sw_req), .brk_req(brk_req),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .flag_rdata(flag_rdata),
    .pin_value(pin_value), .sys_rst_n(sys_rst_n)
  );

  // {bod, wdt, sw, brk, wr, wdata[5:0], expected flags[5:0]}
  localparam logic [16:0] VEC [11] = '{
    {4'b0000, 1'b1, 6'b000000, 6'b000000},
    {4'b0010, 1'b0, 6'b000000, 6'b010000},
    {4'b0001, 1'b0, 6'b000000, 6'b110000},
    {4'b1000, 1'b0, 6'b000000, 6'b110100},
    {4'b0000, 1'b1, 6'b111111, 6'b110100},
    {4'b0000, 1'b1, 6'b101111, 6'b100100},
    {4'b0100, 1'b0, 6'b000000, 6'b001110},
    {4'b0010, 1'b1, 6'b000000, 6'b010000},
    {4'b0101, 1'b0, 6'b000000, 6'b101110},
    {4'b0000, 1'b1, 6'b000000, 6'b000000},
    {4'b1000, 1'b1, 6'b000000, 6'b000100}
  };

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, logic [31:0] actual, logic [31:0] expected);
    total++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic idle();
    bod_det = 0; wdt_expire = 0; sw_req = 0; brk_req = 0; flag_wr = 0; flag_wdata = '0;
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    por_n = 0; pin_rst_n = 1; pin_en = 0; idle();
    @(negedge clk); @(negedge clk);
    chk("R5 reset low at power-on", sys_rst_n, 0);
    chk("R5 power-on flags", flag_rdata, 6'b000110);

    por_n = 1;
    tick(15);
    chk("R10 still low at edge 15", sys_rst_n, 0);
    tick();
    chk("R10 released at edge 16", sys_rst_n, 1);

    for (int v = 0; v < 11; v++) begin
      {bod_det, wdt_expire, sw_req, brk_req} = VEC[v][16:13];
      flag_wr = VEC[v][12];
      flag_wdata = VEC[v][11:6];
      tick();
      idle();
      chk($sformatf("R6 R7 R8 R9 vector %0d", v), flag_rdata, VEC[v][5:0]);
      if (VEC[v][15]) chk("R6 watchdog asserts reset", sys_rst_n, 0);
      tick(20);
    end

    sw_req = 1;
    tick();
    sw_req = 0;
    chk("R10 low at request edge", sys_rst_n, 0);
    tick(15);
    chk("R10 low 15 edges later", sys_rst_n, 0);
    tick();
    chk("R10 high 16 edges later", sys_rst_n, 1);

    flag_wr = 1; flag_wdata = '0; tick(); idle();
    pin_en = 0; pin_rst_n = 0;
    tick(2);
    chk("R1 pin value low after two edges", pin_value, 0);
    tick(5);
    chk("R3 disabled pin no reset", sys_rst_n, 1);
    chk("R3 disabled pin flag clear", flag_rdata, 6'b000000);
    pin_rst_n = 1;
    tick(2);
    chk("R1 pin value high after two edges", pin_value, 1);

    pin_en = 1; pin_rst_n = 0;
    tick(4);
    chk("R2 enabled pin resets", sys_rst_n, 0);
    chk("R2 pin flag set", flag_rdata, 6'b000001);
    pin_rst_n = 1;
    tick(20);
    chk("R10 release after pin", sys_rst_n, 1);

    pin_en = 0; pin_rst_n = 0;
    #2 por_n = 0;
    #1;
    chk("R5 asynchronous assert", sys_rst_n, 0);
    chk("R5 flags reloaded", flag_rdata, 6'b000110);
    @(negedge clk);
    por_n = 1;
    tick(40);
    chk("R4 pin held low keeps reset", sys_rst_n, 0);
    chk("R4 pin flag during power-up", flag_rdata, 6'b000111);
    pin_rst_n = 1;
    tick(20);
    chk("R4 release after pin rises", sys_rst_n, 1);
    pin_rst_n = 0;
    tick(6);
    chk("R4 override ended", sys_rst_n, 1);
    pin_rst_n = 1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule